// File: doc/BRIEF.md
# Interrupt Entry Frame Sequencer

This block carries a processor from a pending event to the first instruction of its handler. It accepts an event only at an instruction boundary and then works out the stack it will use. If the processor is already at kernel privilege, it keeps the current stack. If it is not, it moves to the kernel stack held in the task-state register pair. It then writes the saved-state frame to memory, one word per cycle. After the frame, it reads the two-word gate descriptor that belongs to the event's vector. From that descriptor it produces the handler's code selector and entry offset, together with the final stack segment and pointer.

Each push lowers the stack pointer by four bytes and then writes the word at the new address. The frame is three, four, five or six words long. Its length depends on two things: whether the stack is switched, and whether the event carries an error code. If the descriptor is marked absent, the block raises a fault with the done pulse and keeps the previous code selector and entry offset.

Top module: `intr_entry_seq`

## Requirements
- R1: An event is accepted only in a cycle where `evtReq`, `atBoundary` and not `busy` all hold. `busy` rises in the next cycle and stays high up to and including the `done` cycle. Requests that arrive while `busy` is high are ignored.
- R2: With `curPriv` equal to 0, the stack does not change. The frame starts below `curEsp` and holds, in order, EFLAGS, CS and EIP. `newSs` equals `curSs`.
- R3: With `curPriv` not equal to 0, the frame starts below `kStackEsp` and `newSs` equals `kStackSs`. The frame holds, in order, the old SS, the old ESP, EFLAGS, CS and EIP.
- R4: The error-code word is pushed last, and only when `evtHasErr` was set at acceptance.
- R5: Pushes occur in consecutive cycles, starting in the cycle after acceptance. Each push writes at the previous pointer minus 4. Selectors are zero-extended to 32 bits. No write or read happens while the block is idle.
- R6: In the two cycles after the last push, the block reads `tableBase + vector*8` and then that address plus 4. Read data returns one cycle after the address.
- R7: The descriptor is decoded as follows. The low word's bits 31:16 give the selector. The entry offset is the high word's bits 31:16 concatenated with the low word's bits 15:0. The high word's bit 15 is the present flag.
- R8: `done` is a one-cycle pulse, four cycles after the last push. In that cycle, `newEsp` equals the start pointer minus 4 times the frame length, and `newCs`, `newEip` and `newSs` are valid.
- R9: If the present flag is 0, `fault` is high in the `done` cycle and `newCs` and `newEip` keep their earlier values.
- R10: After reset, `busy`, `done`, `fault`, `memWrEn` and `memRdEn` are low, and all `new*` outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evtReq | input | 1 | Event pending |
| atBoundary | input | 1 | Current instruction has completed |
| evtVector | input | 8 | Event vector number |
| evtHasErr | input | 1 | Event carries an error code |
| evtErrCode | input | 32 | Error code value |
| curPriv | input | 2 | Current privilege level, 0 = kernel |
| curSs | input | 16 | Current stack segment |
| curEsp | input | 32 | Current stack pointer |
| curEflags | input | 32 | Current flags word |
| curCs | input | 16 | Current code segment |
| curEip | input | 32 | Return instruction pointer |
| kStackSs | input | 16 | Kernel stack segment from task state |
| kStackEsp | input | 32 | Kernel stack pointer from task state |
| tableBase | input | 32 | Descriptor table base address |
| memWrEn | output | 1 | Frame write strobe |
| memWrAddr | output | 32 | Frame write byte address |
| memWrData | output | 32 | Frame write word |
| memRdEn | output | 1 | Descriptor read strobe |
| memRdAddr | output | 32 | Descriptor read byte address |
| memRdData | input | 32 | Read word, valid one cycle after the address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry state valid (one cycle) |
| fault | output | 1 | Descriptor absent (with done) |
| newCs | output | 16 | Handler code selector |
| newEip | output | 32 | Handler entry offset |
| newSs | output | 16 | Stack segment after entry |
| newEsp | output | 32 | Stack pointer after entry |

## Verification
The bench builds the block with its default parameters: an 8-bit vector and a 32-bit word. With these values, both ends of the vector range (0 and 255) can be reached, which places the descriptor at the base address and at 2040 bytes above it. A behavioural model predicts, for each cycle, the write strobe, address and data, the read addresses, busy and done. It covers all four frame lengths, an absent descriptor, a request that arrives while the block is busy, and a request that arrives without an instruction boundary.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  localparam int FRAME_MAX = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_RDLO, S_RDHI, S_FIN
  } seqState_t;

  typedef struct packed {
    logic latch;
    logic push;
    logic rdLo;
    logic rdHi;
    logic finish;
  } seqCtl_t;
endpackage

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    evtReq,
  input  logic    atBoundary,
  input  logic    lastPush,
  input  logic    doneIn,
  output seqCtl_t ctl,
  output logic    busy
);
  seqState_t state, stateNext;
  logic accept;

  assign busy   = (state != S_IDLE) || doneIn;
  assign accept = evtReq && atBoundary && !busy;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE: if (accept) stateNext = S_PUSH;
      S_PUSH: if (lastPush) stateNext = S_RDLO;
      S_RDLO: stateNext = S_RDHI;
      S_RDHI: stateNext = S_FIN;
      S_FIN:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.latch  = (state == S_IDLE) && accept;
    ctl.push   = (state == S_PUSH);
    ctl.rdLo   = (state == S_RDLO);
    ctl.rdHi   = (state == S_RDHI);
    ctl.finish = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNext;
  end
endmodule

// File: rtl/intr_entry_dp.sv
module intr_entry_dp
  import intr_entry_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32,
  parameter int PRIV_W = 2,
  localparam int SEL_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCtl_t           ctl,
  input  logic [VEC_W-1:0]  evtVector,
  input  logic              evtHasErr,
  input  logic [WORD_W-1:0] evtErrCode,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic [SEL_W-1:0]  curSs,
  input  logic [WORD_W-1:0] curEsp,
  input  logic [WORD_W-1:0] curEflags,
  input  logic [SEL_W-1:0]  curCs,
  input  logic [WORD_W-1:0] curEip,
  input  logic [SEL_W-1:0]  kStackSs,
  input  logic [WORD_W-1:0] kStackEsp,
  input  logic [WORD_W-1:0] tableBase,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              memRdEn,
  output logic [WORD_W-1:0] memRdAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              lastPush,
  output logic              done,
  output logic              fault,
  output logic [SEL_W-1:0]  newCs,
  output logic [WORD_W-1:0] newEip,
  output logic [SEL_W-1:0]  newSs,
  output logic [WORD_W-1:0] newEsp
);
  localparam int BYTES       = WORD_W / 8;
  localparam int GATE_SHIFT  = $clog2(2 * BYTES);
  localparam int IDX_W       = $clog2(FRAME_MAX + 1);
  localparam int PRESENT_BIT = SEL_W - 1;

  logic [WORD_W-1:0] frameWords [FRAME_MAX];
  logic [WORD_W-1:0] frameNext  [FRAME_MAX];
  logic [IDX_W-1:0]  frameLen, lenNext, pushIdx, baseIdx;
  logic [WORD_W-1:0] stackPtr, gateLo, gateAddr;
  logic [SEL_W-1:0]  stackSel;
  logic [VEC_W-1:0]  vecR;
  logic              switchStack, present;
  logic              unusedHiBits;

  assign switchStack = (curPriv != '0);
  assign baseIdx     = switchStack ? IDX_W'(2) : IDX_W'(0);

  always_comb begin
    for (int i = 0; i < FRAME_MAX; i++) frameNext[i] = '0;
    frameNext[0] = {{(WORD_W-SEL_W){1'b0}}, curSs};
    frameNext[1] = curEsp;
    frameNext[baseIdx]           = curEflags;
    frameNext[baseIdx + IDX_W'(1)] = {{(WORD_W-SEL_W){1'b0}}, curCs};
    frameNext[baseIdx + IDX_W'(2)] = curEip;
    frameNext[baseIdx + IDX_W'(3)] = evtErrCode;
    lenNext = baseIdx + IDX_W'(3) + IDX_W'(evtHasErr);
  end

  assign lastPush  = (pushIdx == frameLen - IDX_W'(1));
  assign memWrEn   = ctl.push;
  assign memWrAddr = stackPtr - WORD_W'(BYTES);
  assign memWrData = frameWords[pushIdx];

  assign gateAddr  = tableBase + (WORD_W'(vecR) << GATE_SHIFT);
  assign memRdEn   = ctl.rdLo | ctl.rdHi;
  assign memRdAddr = ctl.rdHi ? gateAddr + WORD_W'(BYTES) : gateAddr;

  assign present      = memRdData[PRESENT_BIT];
  assign unusedHiBits = ^memRdData[PRESENT_BIT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAME_MAX; i++) frameWords[i] <= '0;
      frameLen <= '0;
      pushIdx  <= '0;
      stackPtr <= '0;
      stackSel <= '0;
      vecR     <= '0;
      gateLo   <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
      newCs    <= '0;
      newEip   <= '0;
      newSs    <= '0;
      newEsp   <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (ctl.latch) begin
        for (int i = 0; i < FRAME_MAX; i++) frameWords[i] <= frameNext[i];
        frameLen <= lenNext;
        pushIdx  <= '0;
        vecR     <= evtVector;
        stackPtr <= switchStack ? kStackEsp : curEsp;
        stackSel <= switchStack ? kStackSs : curSs;
      end
      if (ctl.push) begin
        stackPtr <= stackPtr - WORD_W'(BYTES);
        pushIdx  <= pushIdx + IDX_W'(1);
      end
      if (ctl.rdHi) gateLo <= memRdData;
      if (ctl.finish) begin
        done   <= 1'b1;
        fault  <= !present;
        newEsp <= stackPtr;
        newSs  <= stackSel;
        if (present) begin
          newCs  <= gateLo[WORD_W-1:SEL_W];
          newEip <= {memRdData[WORD_W-1:SEL_W], gateLo[SEL_W-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_entry_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32,
  parameter int PRIV_W = 2,
  localparam int SEL_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtReq,
  input  logic              atBoundary,
  input  logic [VEC_W-1:0]  evtVector,
  input  logic              evtHasErr,
  input  logic [WORD_W-1:0] evtErrCode,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic [SEL_W-1:0]  curSs,
  input  logic [WORD_W-1:0] curEsp,
  input  logic [WORD_W-1:0] curEflags,
  input  logic [SEL_W-1:0]  curCs,
  input  logic [WORD_W-1:0] curEip,
  input  logic [SEL_W-1:0]  kStackSs,
  input  logic [WORD_W-1:0] kStackEsp,
  input  logic [WORD_W-1:0] tableBase,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              memRdEn,
  output logic [WORD_W-1:0] memRdAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [SEL_W-1:0]  newCs,
  output logic [WORD_W-1:0] newEip,
  output logic [SEL_W-1:0]  newSs,
  output logic [WORD_W-1:0] newEsp
);
  seqCtl_t ctl;
  logic    lastPush;

  intr_entry_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evtReq(evtReq), .atBoundary(atBoundary),
    .lastPush(lastPush), .doneIn(done), .ctl(ctl), .busy(busy)
  );

  intr_entry_dp #(.VEC_W(VEC_W), .WORD_W(WORD_W), .PRIV_W(PRIV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .evtVector(evtVector), .evtHasErr(evtHasErr), .evtErrCode(evtErrCode),
    .curPriv(curPriv), .curSs(curSs), .curEsp(curEsp), .curEflags(curEflags),
    .curCs(curCs), .curEip(curEip), .kStackSs(kStackSs), .kStackEsp(kStackEsp),
    .tableBase(tableBase),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .lastPush(lastPush), .done(done), .fault(fault),
    .newCs(newCs), .newEip(newEip), .newSs(newSs), .newEsp(newEsp)
  );
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
  parameter int WORD_W = 32,
  localparam int SEL_W = WORD_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evtReq,
  input logic              atBoundary,
  input logic              memWrEn,
  input logic [WORD_W-1:0] memWrAddr,
  input logic              memRdEn,
  input logic [WORD_W-1:0] memRdAddr,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [SEL_W-1:0]  newCs,
  input logic [WORD_W-1:0] newEip
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(evtReq && atBoundary)) |=> !busy);

  p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && evtReq && atBoundary) |=> (busy && memWrEn));

  p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrEn && $past(memWrEn)) |-> (memWrAddr == $past(memWrAddr) - STEP));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!memWrEn && !memRdEn));

  p_gate_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (memRdEn && $past(memRdEn)) |-> (memRdAddr == $past(memRdAddr) + STEP));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_fault_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> ($stable(newCs) && $stable(newEip)));
endmodule

bind intr_entry_seq intr_entry_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_intr_entry_seq.sv
module tb_intr_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evtReq = 1'b0, atBoundary = 1'b0, evtHasErr = 1'b0;
  logic [7:0]  evtVector = '0;
  logic [31:0] evtErrCode = '0;
  logic [1:0]  curPriv = '0;
  logic [15:0] curSs = 16'h0010, curCs = 16'h0008, kStackSs = 16'h0018;
  logic [31:0] curEsp = 32'h1C00, curEflags = 32'h0000_0202, curEip = 32'h0000_4321;
  logic [31:0] kStackEsp = 32'h1800, tableBase = 32'h0;
  logic        memWrEn, memRdEn, busy, done, fault;
  logic [31:0] memWrAddr, memWrData, memRdAddr, memRdData, newEip, newEsp;
  logic [15:0] newCs, newSs;

  logic [31:0] mem [0:2047];
  int nTests = 0, nFail = 0;
  logic [15:0] mCs = '0;
  logic [31:0] mEip = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_entry_seq dut (.*);

  function automatic logic [31:0] gateWord(input logic [31:0] addr);
    logic [7:0]  v;
    logic [31:0] off;
    logic        pres;
    v    = addr[10:3];
    off  = {8'hC0, v, 8'h5A, v};
    pres = (v % 5) != 3;
    return addr[2] ? {off[31:16], pres, 15'h0} : {16'h0008 + 16'(v), off[15:0]};
  endfunction

  always @(posedge clk) begin
    if (memWrEn) mem[memWrAddr[12:2]] <= memWrData;
    if (memRdEn)
      memRdData <= (memRdAddr < 32'h800) ? gateWord(memRdAddr) : mem[memRdAddr[12:2]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runEvent(input logic [7:0] v, input logic [1:0] priv,
                          input logic hasErr, input logic [31:0] err, input bit midReq);
    logic [31:0] q[$];
    logic [31:0] ptr0;
    logic [15:0] ss;
    logic        pres;
    int n;
    q = {};
    if (priv != 0) begin q.push_back({16'h0, curSs}); q.push_back(curEsp); end
    q.push_back(curEflags); q.push_back({16'h0, curCs}); q.push_back(curEip);
    if (hasErr) q.push_back(err);
    n    = q.size();
    ptr0 = (priv != 0) ? kStackEsp : curEsp;
    ss   = (priv != 0) ? kStackSs : curSs;
    pres = (v % 5) != 3;
    @(negedge clk);
    curPriv = priv; evtVector = v; evtHasErr = hasErr; evtErrCode = err;
    evtReq = 1'b1; atBoundary = 1'b1;
    for (int k = 1; k <= n + 5; k++) begin
      @(negedge clk);
      if (k == 1) evtReq = 1'b0;
      if (midReq && k == 2) evtReq = 1'b1;
      if (k == 3) evtReq = 1'b0;
      chk("R1 busy", {31'h0, busy}, {31'h0, k <= n + 4});
      chk("R5 write strobe", {31'h0, memWrEn}, {31'h0, k <= n});
      if (k <= n) begin
        chk("R5 write address", memWrAddr, ptr0 - 32'(4 * k));
        chk((priv != 0) ? "R3 frame word" : (k == n && hasErr) ? "R4 error word" : "R2 frame word",
            memWrData, q[k-1]);
      end
      chk("R6 read strobe", {31'h0, memRdEn}, {31'h0, k == n + 1 || k == n + 2});
      if (k == n + 1) chk("R6 low address", memRdAddr, tableBase + 32'(v) * 8);
      if (k == n + 2) chk("R6 high address", memRdAddr, tableBase + 32'(v) * 8 + 4);
      chk("R8 done", {31'h0, done}, {31'h0, k == n + 4});
      if (k == n + 4) begin
        chk("R9 fault", {31'h0, fault}, {31'h0, !pres});
        if (pres) begin mCs = 16'h0008 + 16'(v); mEip = {8'hC0, v, 8'h5A, v}; end
        chk(pres ? "R7 new selector" : "R9 selector kept", {16'h0, newCs}, {16'h0, mCs});
        chk(pres ? "R7 new offset" : "R9 offset kept", newEip, mEip);
        chk("R8 new stack pointer", newEsp, ptr0 - 32'(4 * n));
        chk((priv != 0) ? "R3 new stack segment" : "R2 new stack segment",
            {16'h0, newSs}, {16'h0, ss});
      end
    end
    atBoundary = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nTests + 1, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy", {31'h0, busy}, 32'h0);
    chk("R10 done", {31'h0, done}, 32'h0);
    chk("R10 fault", {31'h0, fault}, 32'h0);
    chk("R10 strobes", {30'h0, memWrEn, memRdEn}, 32'h0);
    chk("R10 outputs", newEip | newEsp | {16'h0, newCs} | {16'h0, newSs}, 32'h0);

    evtReq = 1'b1; atBoundary = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 no boundary idle", {30'h0, busy, memWrEn}, 32'h0);
    end
    evtReq = 1'b0;

    runEvent(8'd32, 2'd0, 1'b0, 32'h0, 1'b0);
    curEsp = 32'h1B00; curEip = 32'h0000_7777;
    runEvent(8'd14, 2'd0, 1'b1, 32'hDEAD_0004, 1'b0);
    runEvent(8'd64, 2'd3, 1'b0, 32'h0, 1'b1);
    kStackEsp = 32'h1700; curEflags = 32'h0000_0046;
    runEvent(8'd13, 2'd3, 1'b1, 32'h0000_0BAD, 1'b0);
    runEvent(8'd0, 2'd1, 1'b0, 32'h0, 1'b0);
    runEvent(8'd255, 2'd0, 1'b1, 32'h1234_5678, 1'b0);
    runEvent(8'd8, 2'd0, 1'b1, 32'h0, 1'b0);
    runEvent(8'd3, 2'd2, 1'b0, 32'h0, 1'b1);
    runEvent(8'd200, 2'd0, 1'b0, 32'h0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule